// File: doc/BRIEF.md
# Memory Test Write-Sequence Generator

This block produces a burst of word writes toward a memory for built-in self-test. A run is configured with a base byte address, an end byte address, a length in bytes and two mode bits. A one-cycle `start` pulse latches the configuration and opens the burst. The block then presents one write at a time on a single valid/ready port. Each write carries a word address and a data word. When the last write has been accepted, `done` is raised.

The word offset inside the window is masked with (window words − 1). A window whose size is a power of two therefore wraps cleanly, and later words overwrite earlier locations. In the default mode the data is the running word count and the offset is that same count. Two mode bits switch the data and the offset, each on its own, to the state of a maximal-length LFSR. The LFSR steps once per accepted write.

The controller has three states:
- `ST_IDLE`: the state after reset.
- `ST_BURST`: writes are offered.
- `ST_DONE`: the burst has finished.

It has four transitions:
- *launch*: IDLE/DONE → BURST, on `start` with a nonzero word count.
- *empty launch*: IDLE/DONE → DONE, on `start` with a zero word count.
- *last accept*: BURST → DONE, when the final word is accepted.
- *hold*: every other case keeps the current state.

Top module: `memtest_wrgen`

## Requirements
- R1: After reset, `cmd_valid` and `done` are 0.
- R2: A run writes exactly floor(`cfg_len` / (DATA_W/8)) words. A length below one word issues no write, and `done` is 1 on the first cycle after the `start` pulse.
- R3: With both mode bits 0, the k-th accepted word (k from 0) carries data k, zero-extended.
- R4: The word address is `cfg_base`/(DATA_W/8) + (offset AND mask). The mask is (`cfg_end` − `cfg_base`)/(DATA_W/8) − 1. In the default mode the offset is k.
- R5: The window wraps. With 32-bit words, base 4, end 20 and length 24, words 1..4 end up holding 4, 5, 2, 3.
- R6: A window size that is not a power of two is not corrected. The mask is used bitwise. With base 0, end 24 and length 32 at 32-bit words, the offsets are 0,1,0,1,4,5,4,5.
- R7: While `cmd_valid` is high and `cmd_ready` is low, `cmd_valid`, `cmd_addr` and `cmd_wdata` hold. The sequence advances only when valid and ready are both high.
- R8: `done` rises on the cycle after the last accepted write. It stays high, with `cmd_valid` low, until the next `start`.
- R9: A `start` pulse or configuration change during a burst has no effect on that burst.
- R10: With `cfg_rand_data` set, the data is the LFSR state. The LFSR is a right-shifting Galois LFSR with taps 0x80200003 (XOR applied when the bit shifted out is 1). It is loaded with 0x00000001 at reset and at each `start`. Within a burst no value repeats and the values do not count up from 0.
- R11: With `cfg_rand_addr` set, the offset is the low LFSR bits before masking. The write order is not sequential, and the data (the word count) stays below the number of words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_base | input | ADDR_W | Base byte address |
| cfg_end | input | ADDR_W | Byte address bounding the window |
| cfg_len | input | LEN_W | Burst length in bytes |
| cfg_rand_data | input | 1 | Pseudo-random data mode |
| cfg_rand_addr | input | 1 | Pseudo-random address mode |
| start | input | 1 | One-cycle run pulse |
| done | output | 1 | Burst complete |
| cmd_valid | output | 1 | Write offered |
| cmd_ready | input | 1 | Memory accepts the write |
| cmd_addr | output | ADDR_W − log2(DATA_W/8) | Word address |
| cmd_wdata | output | DATA_W | Write data |

## Verification
On every cycle, the assertions check four things:
- the port holds still through a stall;
- `done` never overlaps `cmd_valid` and is sticky without `start`;
- the word count stays below the latched total while writing;
- each offered address lies within the masked window above the base.

The actual address/data sequence cannot be judged cycle by cycle and needs the bench's scenarios. This covers the wrap overwrite image, the non-power-of-two image, the LFSR orderings, zero-length runs, the timing of `done`, and ignored mid-burst starts. The bench compares each accepted write against a queue built from the requirements.

// File: rtl/memtest_pkg.sv
package memtest_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BURST = 2'd1,
        ST_DONE  = 2'd2
    } mtg_state_e;
endpackage

// File: rtl/mtg_fit.sv
module mtg_fit #(
    parameter int IN_W  = 32,
    parameter int OUT_W = 32
) (
    input  logic [IN_W-1:0]  din,
    output logic [OUT_W-1:0] dout
);
    generate
        if (IN_W >= OUT_W) begin : g_trunc
            assign dout = din[OUT_W-1:0];
        end else begin : g_pad
            assign dout = {{(OUT_W-IN_W){1'b0}}, din};
        end
    endgenerate
endmodule

// File: rtl/mtg_lfsr.sv
module mtg_lfsr #(
    parameter int               W    = 32,
    parameter logic [W-1:0]     TAPS = 32'h80200003,
    parameter logic [W-1:0]     SEED = 32'h00000001
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         step,
    output logic [W-1:0] state
);
    logic [W-1:0] nxt;

    always_comb begin
        nxt = state >> 1;
        if (state[0]) nxt = nxt ^ TAPS;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)    state <= SEED;
        else if (load) state <= SEED;
        else if (step) state <= nxt;
    end

    // R10
    lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state != '0);
endmodule

// File: rtl/mtg_fsm.sv
module mtg_fsm
    import memtest_pkg::*;
#(
    parameter int CNT_W = 30
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             empty_run,
    input  logic [CNT_W-1:0] total,
    input  logic             ready,
    output logic             valid,
    output logic             done,
    output logic             load,
    output logic             accept,
    output logic [CNT_W-1:0] count
);
    mtg_state_e state_q, state_d;
    logic       last_word;

    assign last_word = (count == total - 1'b1);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_DONE: begin
                if (start) state_d = empty_run ? ST_DONE : ST_BURST;
            end
            ST_BURST: begin
                if (accept && last_word) state_d = ST_DONE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        valid  = (state_q == ST_BURST);
        done   = (state_q == ST_DONE);
        load   = start && (state_q != ST_BURST);
        accept = valid && ready;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      count <= '0;
        else if (load)   count <= '0;
        else if (accept) count <= count + 1'b1;
    end

    // R7
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid && !ready |=> valid && $stable(count));
    // R8
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done && !start |=> done);
    // R8
    done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(valid && done));
    // R2
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> count < total);
endmodule

// File: rtl/mtg_addr_gen.sv
module mtg_addr_gen #(
    parameter int WADDR_W = 30,
    parameter int CNT_W   = 30,
    parameter int LFSR_W  = 32
) (
    input  logic [WADDR_W-1:0] base_word,
    input  logic [WADDR_W-1:0] mask,
    input  logic [CNT_W-1:0]   count,
    input  logic [LFSR_W-1:0]  lfsr,
    input  logic               rand_addr,
    output logic [WADDR_W-1:0] addr
);
    logic [WADDR_W-1:0] cnt_off, lfsr_off, off;

    mtg_fit #(.IN_W(CNT_W),  .OUT_W(WADDR_W)) u_fit_cnt  (.din(count), .dout(cnt_off));
    mtg_fit #(.IN_W(LFSR_W), .OUT_W(WADDR_W)) u_fit_lfsr (.din(lfsr),  .dout(lfsr_off));

    always_comb begin
        off  = rand_addr ? lfsr_off : cnt_off;
        addr = base_word + (off & mask);
    end
endmodule

// File: rtl/memtest_wrgen.sv
module memtest_wrgen
    import memtest_pkg::*;
#(
    parameter int                DATA_W    = 32,
    parameter int                ADDR_W    = 32,
    parameter int                LEN_W     = 32,
    parameter int                LFSR_W    = 32,
    parameter logic [LFSR_W-1:0] LFSR_TAPS = 32'h80200003,
    parameter logic [LFSR_W-1:0] LFSR_SEED = 32'h00000001,
    localparam int               BYTES     = DATA_W / 8,
    localparam int               BSH       = $clog2(BYTES),
    localparam int               WADDR_W   = ADDR_W - BSH,
    localparam int               CNT_W     = LEN_W - BSH
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  cfg_base,
    input  logic [ADDR_W-1:0]  cfg_end,
    input  logic [LEN_W-1:0]   cfg_len,
    input  logic               cfg_rand_data,
    input  logic               cfg_rand_addr,
    input  logic               start,
    output logic               done,
    output logic               cmd_valid,
    input  logic               cmd_ready,
    output logic [WADDR_W-1:0] cmd_addr,
    output logic [DATA_W-1:0]  cmd_wdata
);
    logic [WADDR_W-1:0] base_wq, mask_q;
    logic [CNT_W-1:0]   total_q, count, cfg_total;
    logic               rdata_q, raddr_q;
    logic               load, accept;
    logic [LFSR_W-1:0]  lfsr;
    logic [DATA_W-1:0]  cnt_data, lfsr_data;

    assign cfg_total = cfg_len[LEN_W-1:BSH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_wq <= '0;
            mask_q  <= '0;
            total_q <= '0;
            rdata_q <= 1'b0;
            raddr_q <= 1'b0;
        end else if (load) begin
            base_wq <= cfg_base[ADDR_W-1:BSH];
            mask_q  <= cfg_end[ADDR_W-1:BSH] - cfg_base[ADDR_W-1:BSH] - 1'b1;
            total_q <= cfg_total;
            rdata_q <= cfg_rand_data;
            raddr_q <= cfg_rand_addr;
        end
    end

    mtg_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .empty_run (cfg_total == '0),
        .total     (total_q),
        .ready     (cmd_ready),
        .valid     (cmd_valid),
        .done      (done),
        .load      (load),
        .accept    (accept),
        .count     (count)
    );

    mtg_lfsr #(.W(LFSR_W), .TAPS(LFSR_TAPS), .SEED(LFSR_SEED)) u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .step  (accept),
        .state (lfsr)
    );

    mtg_addr_gen #(.WADDR_W(WADDR_W), .CNT_W(CNT_W), .LFSR_W(LFSR_W)) u_addr (
        .base_word (base_wq),
        .mask      (mask_q),
        .count     (count),
        .lfsr      (lfsr),
        .rand_addr (raddr_q),
        .addr      (cmd_addr)
    );

    mtg_fit #(.IN_W(CNT_W),  .OUT_W(DATA_W)) u_fit_cdat (.din(count), .dout(cnt_data));
    mtg_fit #(.IN_W(LFSR_W), .OUT_W(DATA_W)) u_fit_ldat (.din(lfsr),  .dout(lfsr_data));

    assign cmd_wdata = rdata_q ? lfsr_data : cnt_data;

    // R7
    cmd_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_addr) && $stable(cmd_wdata));
    // R4
    in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (cmd_addr - base_wq) <= mask_q);
    // R9
    cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && $past(cmd_valid) |-> $stable(base_wq) && $stable(total_q));
endmodule

// File: tb/tb_memtest_wrgen.sv
module tb_memtest_wrgen;
    localparam int DW = 32;
    localparam int AW = 32;
    localparam int WA = 30;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] cfg_base = '0, cfg_end = '0;
    logic [31:0]   cfg_len = '0;
    logic          cfg_rand_data = 1'b0, cfg_rand_addr = 1'b0;
    logic          start = 1'b0;
    logic          done, cmd_valid;
    logic          cmd_ready = 1'b1;
    logic [WA-1:0] cmd_addr;
    logic [DW-1:0] cmd_wdata;

    memtest_wrgen dut (
        .clk(clk), .rst_n(rst_n), .cfg_base(cfg_base), .cfg_end(cfg_end),
        .cfg_len(cfg_len), .cfg_rand_data(cfg_rand_data), .cfg_rand_addr(cfg_rand_addr),
        .start(start), .done(done), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata)
    );

    always #5 clk = ~clk;

    typedef struct packed { logic [WA-1:0] addr; logic [DW-1:0] data; } item_t;
    item_t       exp_q[$];
    logic [DW-1:0] obs_data[$];
    logic [WA-1:0] obs_addr[$];
    logic [DW-1:0] mem [0:63];
    int n_chk = 0, n_fail = 0;
    int cyc = 0, last_acc = -10;
    logic stall_en = 1'b0;
    string cur_req = "R3";

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] lstep(input logic [31:0] s);
        return s[0] ? ((s >> 1) ^ 32'h80200003) : (s >> 1);
    endfunction

    // ready driver, away from the edge
    initial begin
        int ph = 0;
        forever begin
            @(posedge clk); #2;
            ph++;
            cmd_ready = stall_en ? ((ph % 3) != 1) : 1'b1;
        end
    end

    // monitor / scoreboard
    initial begin
        logic          held = 1'b0;
        logic [WA-1:0] h_addr = '0;
        logic [DW-1:0] h_data = '0;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (held && cmd_valid)
                    check(cmd_addr == h_addr && cmd_wdata == h_data, "R7", "stall hold",
                          {cmd_addr, cmd_wdata[31:0]}, {h_addr, h_data[31:0]});
                held = cmd_valid && !cmd_ready;
                h_addr = cmd_addr; h_data = cmd_wdata;
                if (cmd_valid && cmd_ready) begin
                    item_t e;
                    last_acc = cyc;
                    mem[cmd_addr[5:0]] = cmd_wdata;
                    obs_data.push_back(cmd_wdata);
                    obs_addr.push_back(cmd_addr);
                    if (exp_q.size() == 0) begin
                        check(1'b0, cur_req, "unexpected write", {cmd_addr, cmd_wdata}, 0);
                    end else begin
                        e = exp_q.pop_front();
                        check(cmd_addr == e.addr, cur_req, "addr", cmd_addr, e.addr);
                        check(cmd_wdata == e.data, cur_req, "data", cmd_wdata, e.data);
                    end
                end
            end
        end
    end

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 64; i++) mem[i] = '0;
        obs_data.delete(); obs_addr.delete();
    endtask

    // driver: builds expected items from the requirements, then runs the burst
    task automatic run_burst(input logic [31:0] b, input logic [31:0] e, input logic [31:0] len,
                             input bit rd, input bit ra, input string req, input bit poke);
        logic [31:0] s = 32'h1;
        logic [WA-1:0] msk = WA'((e >> 2) - (b >> 2) - 1);
        int nw = int'(len >> 2);
        int t = 0;
        cur_req = req;
        for (int k = 0; k < nw; k++) begin
            item_t it;
            logic [WA-1:0] off = ra ? s[WA-1:0] : WA'(k);
            it.addr = WA'(b >> 2) + (off & msk);
            it.data = rd ? s : DW'(k);
            exp_q.push_back(it);
            s = lstep(s);
        end
        cfg_base = b; cfg_end = e; cfg_len = len; cfg_rand_data = rd; cfg_rand_addr = ra;
        pulse_start();
        if (poke) begin
            repeat (2) @(negedge clk);
            // R9: start and new config mid-burst must be ignored
            cfg_base = 32'h100; cfg_len = 32'h4; start = 1'b1;
            @(negedge clk); start = 1'b0;
        end
        while (!done && t < 3000) begin @(negedge clk); t++; end
        check(done == 1'b1, "R8", "done reached", done, 1);
        if (nw > 0)
            check(cyc == last_acc + 1, "R8", "done one cycle after last write", cyc, last_acc + 1);
        check(exp_q.size() == 0, "R2", "all words written", exp_q.size(), 0);
        exp_q.delete();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(cmd_valid == 1'b0, "R1", "valid at reset", cmd_valid, 0);
        check(done == 1'b0, "R1", "done at reset", done, 0);
        rst_n = 1'b1;

        // R3 / R4: default counting, with stalls (R7)
        stall_en = 1'b1;
        clear_mem();
        run_burst(32'h10, 32'h50, 32'd32, 1'b0, 1'b0, "R3", 1'b0);

        // R5: power-of-two wrap image
        clear_mem();
        run_burst(32'd4, 32'd20, 32'd24, 1'b0, 1'b0, "R5", 1'b0);
        check(mem[1] == 4 && mem[2] == 5 && mem[3] == 2 && mem[4] == 3, "R5", "wrap image",
              {mem[1][15:0], mem[2][15:0], mem[3][15:0], mem[4][15:0]}, 64'h0004000500020003);

        // R6: non-power-of-two window is not corrected
        clear_mem();
        run_burst(32'd0, 32'd24, 32'd32, 1'b0, 1'b0, "R6", 1'b0);
        check(mem[0] == 2 && mem[1] == 3 && mem[4] == 6 && mem[5] == 7, "R6", "uncorrected image",
              {mem[0][15:0], mem[1][15:0], mem[4][15:0], mem[5][15:0]}, 64'h0002000300060007);

        // R2: length below a word, then truncated length
        clear_mem();
        run_burst(32'd0, 32'd64, 32'd3, 1'b0, 1'b0, "R2", 1'b0);
        check(obs_data.size() == 0, "R2", "no write for short length", obs_data.size(), 0);
        run_burst(32'd0, 32'd64, 32'd10, 1'b0, 1'b0, "R2", 1'b0);
        check(obs_data.size() == 2, "R2", "truncated word count", obs_data.size(), 2);

        // R9: mid-burst start ignored
        clear_mem();
        run_burst(32'h20, 32'h60, 32'd40, 1'b0, 1'b0, "R9", 1'b1);

        // R8: done sticky without start
        cfg_base = 32'h8; cfg_len = 32'd64;
        repeat (5) @(negedge clk);
        check(done == 1'b1 && cmd_valid == 1'b0, "R8", "done held", {done, cmd_valid}, 2'b10);

        // R10: random data
        stall_en = 1'b0;
        clear_mem();
        run_burst(32'd0, 32'd256, 32'd128, 1'b1, 1'b0, "R10", 1'b0);
        begin
            bit dup = 1'b0, seq = 1'b1;
            for (int i = 0; i < obs_data.size(); i++) begin
                if (obs_data[i] != DW'(i)) seq = 1'b0;
                for (int j = 0; j < i; j++) if (obs_data[i] == obs_data[j]) dup = 1'b1;
            end
            check(!dup, "R10", "no duplicate data", dup, 0);
            check(!seq, "R10", "data not counting", seq, 0);
        end

        // R11: random addresses
        stall_en = 1'b1;
        clear_mem();
        run_burst(32'd0, 32'd256, 32'd128, 1'b0, 1'b1, "R11", 1'b0);
        begin
            bit sq = 1'b1, big = 1'b0;
            for (int i = 0; i < obs_addr.size(); i++) begin
                if (i > 0 && obs_addr[i] != obs_addr[i-1] + 1'b1) sq = 1'b0;
                if (obs_data[i] >= 32) big = 1'b1;
            end
            check(!sq, "R11", "address order not sequential", sq, 0);
            check(!big, "R11", "data below word count", big, 0);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog run hung actual=%0d expected=%0d", cyc, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule